// File: doc/BRIEF.md
# UART Software Flow-Control Engine

This block sits on the receive path of a UART, between the deserialiser and the receive FIFO, and next to the transmitter. It watches every received byte for software flow-control characters. A stop character raises a halt output that tells the transmitter to pause. A resume character drops that output. Recognised control characters are removed from the data stream, and all other bytes go on to the FIFO one clock later.

Four programmable character registers hold two stop characters and two resume characters. A 4-bit mode field chooses, separately for each direction, which of them apply. The receive side can compare against the first set, the second set, or a two-byte sequence made of both. The transmit side emits one-cycle requests to send a stop or resume byte pair when FIFO level thresholds are crossed. It also presents the one or two characters to send.

A special-character mode is available when all flow control is off. In that mode any byte equal to the second stop character is still stored, and a sticky interrupt flag is raised. The mode field and the special-character enable sit behind a write-protect bit.

Top module: `uart_swfc`

## Requirements
- R1: After reset the mode field, the special-character enable and the write-protect bit are all 0. `tx_halt`, `fifo_wr`, `send_xon`, `send_xoff`, `tx_two` and `spc_irq` are all 0.
- R2: A control write (`ctl_wdata` bit 5 = unlock, bit 4 = special enable, bits 3:0 = mode) always updates the unlock bit. It changes the mode and the special enable only if the unlock bit stored before that write is 1. Otherwise those two fields keep their value.
- R3: With receive mode bits [1:0] = 00, every received byte appears on `fifo_data` with `fifo_wr` high one clock after `rx_valid`.
- R4: With receive mode 10, a byte equal to stop character 1 sets `tx_halt` on the next clock, and one equal to resume character 1 clears it. Neither byte is written to the FIFO. All other bytes pass, including the set-2 characters. Comparison is bitwise, with register bit 0 against received bit 0.
- R5: With receive mode 01 the same behaviour applies using stop character 2 and resume character 2.
- R6: With receive mode 11, stop 1 immediately followed by stop 2 sets `tx_halt`, and resume 1 followed by resume 2 clears it. None of these bytes reaches the FIFO.
- R7: In mode 11, when a held first byte is not followed by its partner, the held byte is written one clock after the second byte arrives. If the second byte is not itself a first-of-pair character, it is written on the following clock. If it is one, it becomes the new held byte.
- R8: With transmit bits [3:2] non-zero, `lvl_hi` while not paused gives a one-cycle `send_xoff` on the next clock, and `lvl_lo` while paused gives a one-cycle `send_xon`. No second request is issued until the other threshold is seen. The characters come out as: 10 gives set 1 on `tx_char_a`; 01 gives set 2 on `tx_char_a`; 11 gives set 1 on `tx_char_a`, set 2 on `tx_char_b` and `tx_two` = 1.
- R9: With transmit bits [3:2] = 00, no transmit request is ever issued.
- R10: With the whole mode field 0 and the special enable set, a byte equal to stop character 2 is still written to the FIFO, and `spc_irq` is 1 on the next clock. With any mode bit set, the flag is not raised.
- R11: `spc_irq` stays 1 until `irq_clr`. A new match in the same cycle as `irq_clr` keeps it at 1.
- R12: While receive mode bits are 00, `tx_halt` is cleared on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Unlock, special enable, mode |
| chr_we | input | 1 | Character register write strobe |
| chr_sel | input | 2 | Character select: 0 resume1, 1 resume2, 2 stop1, 3 stop2 |
| chr_wdata | input | 8 | Character value |
| rx_valid | input | 1 | Received byte strobe (at least one idle cycle between bytes) |
| rx_data | input | 8 | Received byte, bit 0 first-received LSB |
| fifo_wr | output | 1 | Write strobe to receive FIFO |
| fifo_data | output | 8 | Byte to receive FIFO |
| tx_halt | output | 1 | Transmitter pause request |
| lvl_hi | input | 1 | Receive FIFO above high threshold |
| lvl_lo | input | 1 | Receive FIFO below low threshold |
| send_xoff | output | 1 | One-cycle request to send stop characters |
| send_xon | output | 1 | One-cycle request to send resume characters |
| tx_two | output | 1 | Request carries two characters |
| tx_char_a | output | 8 | First character to send |
| tx_char_b | output | 8 | Second character to send |
| irq_clr | input | 1 | Read-clear strobe for the special flag |
| spc_irq | output | 1 | Special character seen |

## Verification
The bench goes after the pair sequence that breaks halfway. A design that forgets the held byte loses data, and one that forwards it in the wrong cycle reorders the stream. It checks that a write to the mode field while locked is ignored: a leaky lock would start stripping characters that should pass. It also checks the interrupt clear colliding with a new match, where a clear-wins design loses an event, and a threshold held high for several cycles, where a design without hysteresis repeats its stop request.

// File: rtl/uart_swfc_pkg.sv
// Package: shared widths, character indices and encodings for the
// software flow-control engine. Assumes 8-bit characters.
package uart_swfc_pkg;
    localparam int CHAR_W    = 8;
    localparam int NUM_CHARS = 4;
    localparam int MODE_W    = 4;
    localparam int SEL_W     = $clog2(NUM_CHARS);
    localparam int SPC_BIT   = MODE_W;
    localparam int ENH_BIT   = MODE_W + 1;
    localparam int CTL_W     = MODE_W + 2;

    typedef logic [CHAR_W-1:0] char_t;

    // Character register indices; the select encoding is part of the interface.
    typedef enum logic [SEL_W-1:0] {
        CH_XON1  = 2'd0,
        CH_XON2  = 2'd1,
        CH_XOFF1 = 2'd2,
        CH_XOFF2 = 2'd3
    } char_idx_e;

    // Two-bit direction selector used by both halves of the mode field.
    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_SET2 = 2'b01,
        FC_SET1 = 2'b10,
        FC_BOTH = 2'b11
    } fc_sel_e;

    // Receive pairing state.
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_OFF1  = 2'd1,
        HS_ON1   = 2'd2,
        HS_FLUSH = 2'd3
    } hold_e;
endpackage

// File: rtl/uart_swfc_cfg.sv
// Configuration store: the unlock bit, the write-protected mode field and
// special enable, and the character registers.
// Assumes the unlock bit that guards a write is the one stored before it.
module uart_swfc_cfg
    import uart_swfc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctl_we,
    input  logic [CTL_W-1:0]            ctl_wdata,
    input  logic                        chr_we,
    input  logic [SEL_W-1:0]            chr_sel,
    input  char_t                       chr_wdata,
    output logic [MODE_W-1:0]           mode,
    output logic                        spc_en,
    output char_t [NUM_CHARS-1:0]       chars
);
    logic unlock_q;

    // Unlock bit always writable; protected fields follow it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
            mode     <= '0;
            spc_en   <= 1'b0;
        end else if (ctl_we) begin
            unlock_q <= ctl_wdata[ENH_BIT];
            if (unlock_q) begin
                mode   <= ctl_wdata[MODE_W-1:0];
                spc_en <= ctl_wdata[SPC_BIT];
            end
        end
    end

    // One register per flow-control character.
    for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
        char_t char_q;
        // Load this character when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                char_q <= '0;
            else if (chr_we && chr_sel == SEL_W'(i))
                char_q <= chr_wdata;
        end
        assign chars[i] = char_q;
    end
endmodule

// File: rtl/uart_swfc_rx.sv
// Receive filter: classifies each received byte against the selected
// flow-control characters, drives the halt output and forwards data bytes.
// Also raises the sticky special-character flag.
// Assumes rx_valid is never high on two consecutive cycles, and that the
// mode changes only while no byte is being held.
module uart_swfc_rx
    import uart_swfc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MODE_W-1:0]           mode,
    input  logic                        spc_en,
    input  char_t [NUM_CHARS-1:0]       chars,
    input  logic                        rx_valid,
    input  char_t                       rx_data,
    input  logic                        irq_clr,
    output logic                        fifo_wr,
    output char_t                       fifo_data,
    output logic                        tx_halt,
    output logic                        spc_irq
);
    fc_sel_e rx_sel;
    char_t   on_c, off_c;
    hold_e   st_q;
    char_t   held_q;
    logic    spc_hit;

    assign rx_sel = fc_sel_e'(mode[1:0]);

    // Pick the character set for single-set receive modes.
    always_comb begin
        if (rx_sel == FC_SET2) begin
            on_c  = chars[CH_XON2];
            off_c = chars[CH_XOFF2];
        end else begin
            on_c  = chars[CH_XON1];
            off_c = chars[CH_XOFF1];
        end
    end

    // Special-character match: only when all flow control is off.
    assign spc_hit = rx_valid && (mode == '0) && spc_en &&
                     (rx_data == chars[CH_XOFF2]);

    // Classify bytes, maintain halt, pairing state and FIFO writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            tx_halt   <= 1'b0;
            st_q      <= HS_IDLE;
            held_q    <= '0;
        end else begin
            fifo_wr <= 1'b0;
            if (rx_sel == FC_NONE)
                tx_halt <= 1'b0;
            if (rx_valid) begin
                unique case (rx_sel)
                    FC_NONE: begin
                        fifo_wr   <= 1'b1;
                        fifo_data <= rx_data;
                    end
                    FC_SET1, FC_SET2: begin
                        if (rx_data == off_c)
                            tx_halt <= 1'b1;
                        else if (rx_data == on_c)
                            tx_halt <= 1'b0;
                        else begin
                            fifo_wr   <= 1'b1;
                            fifo_data <= rx_data;
                        end
                    end
                    FC_BOTH: begin
                        if (st_q == HS_OFF1 && rx_data == chars[CH_XOFF2]) begin
                            tx_halt <= 1'b1;
                            st_q    <= HS_IDLE;
                        end else if (st_q == HS_ON1 && rx_data == chars[CH_XON2]) begin
                            tx_halt <= 1'b0;
                            st_q    <= HS_IDLE;
                        end else begin
                            if (st_q != HS_IDLE) begin
                                fifo_wr   <= 1'b1;
                                fifo_data <= held_q;
                            end
                            if (rx_data == chars[CH_XOFF1]) begin
                                st_q   <= HS_OFF1;
                                held_q <= rx_data;
                            end else if (rx_data == chars[CH_XON1]) begin
                                st_q   <= HS_ON1;
                                held_q <= rx_data;
                            end else if (st_q != HS_IDLE) begin
                                st_q   <= HS_FLUSH;
                                held_q <= rx_data;
                            end else begin
                                fifo_wr   <= 1'b1;
                                fifo_data <= rx_data;
                            end
                        end
                    end
                endcase
            end else if (st_q == HS_FLUSH || (st_q != HS_IDLE && rx_sel != FC_BOTH)) begin
                fifo_wr   <= 1'b1;
                fifo_data <= held_q;
                st_q      <= HS_IDLE;
            end
        end
    end

    // Sticky special flag; a new match beats the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spc_irq <= 1'b0;
        else if (spc_hit)
            spc_irq <= 1'b1;
        else if (irq_clr)
            spc_irq <= 1'b0;
    end
endmodule

// File: rtl/uart_swfc_tx.sv
// Transmit request generator: turns FIFO threshold levels into one-cycle
// send requests with hysteresis, and presents the characters to send.
// Assumes lvl_hi and lvl_lo are synchronous levels from the FIFO.
module uart_swfc_tx
    import uart_swfc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MODE_W-1:0]           mode,
    input  char_t [NUM_CHARS-1:0]       chars,
    input  logic                        lvl_hi,
    input  logic                        lvl_lo,
    output logic                        send_xoff,
    output logic                        send_xon,
    output logic                        tx_two,
    output char_t                       tx_char_a,
    output char_t                       tx_char_b
);
    fc_sel_e tx_sel;
    logic    paused_q;
    char_t   off_a, off_b, on_a, on_b;

    assign tx_sel = fc_sel_e'(mode[MODE_W-1:MODE_W-2]);

    // Characters per transmit selection; pair order is set 1 then set 2.
    always_comb begin
        off_b = '0;
        on_b  = '0;
        if (tx_sel == FC_SET2) begin
            off_a = chars[CH_XOFF2];
            on_a  = chars[CH_XON2];
        end else begin
            off_a = chars[CH_XOFF1];
            on_a  = chars[CH_XON1];
        end
        if (tx_sel == FC_BOTH) begin
            off_b = chars[CH_XOFF2];
            on_b  = chars[CH_XON2];
        end
    end

    // Hysteresis state and registered one-cycle requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused_q  <= 1'b0;
            send_xoff <= 1'b0;
            send_xon  <= 1'b0;
            tx_two    <= 1'b0;
            tx_char_a <= '0;
            tx_char_b <= '0;
        end else begin
            send_xoff <= 1'b0;
            send_xon  <= 1'b0;
            tx_two    <= 1'b0;
            tx_char_a <= '0;
            tx_char_b <= '0;
            if (tx_sel == FC_NONE) begin
                paused_q <= 1'b0;
            end else if (!paused_q && lvl_hi) begin
                paused_q  <= 1'b1;
                send_xoff <= 1'b1;
                tx_two    <= (tx_sel == FC_BOTH);
                tx_char_a <= off_a;
                tx_char_b <= off_b;
            end else if (paused_q && lvl_lo) begin
                paused_q  <= 1'b0;
                send_xon  <= 1'b1;
                tx_two    <= (tx_sel == FC_BOTH);
                tx_char_a <= on_a;
                tx_char_b <= on_b;
            end
        end
    end
endmodule

// File: rtl/uart_swfc.sv
// Top of the software flow-control engine: configuration store, receive
// filter and transmit request generator.
// Assumes a receiver that spaces rx_valid by at least one idle cycle.
module uart_swfc
    import uart_swfc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [CTL_W-1:0]     ctl_wdata,
    input  logic                 chr_we,
    input  logic [SEL_W-1:0]     chr_sel,
    input  logic [CHAR_W-1:0]    chr_wdata,
    input  logic                 rx_valid,
    input  logic [CHAR_W-1:0]    rx_data,
    output logic                 fifo_wr,
    output logic [CHAR_W-1:0]    fifo_data,
    output logic                 tx_halt,
    input  logic                 lvl_hi,
    input  logic                 lvl_lo,
    output logic                 send_xoff,
    output logic                 send_xon,
    output logic                 tx_two,
    output logic [CHAR_W-1:0]    tx_char_a,
    output logic [CHAR_W-1:0]    tx_char_b,
    input  logic                 irq_clr,
    output logic                 spc_irq
);
    logic [MODE_W-1:0]       mode;
    logic                    spc_en;
    char_t [NUM_CHARS-1:0]   chars;

    uart_swfc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .chr_we    (chr_we),
        .chr_sel   (chr_sel),
        .chr_wdata (chr_wdata),
        .mode      (mode),
        .spc_en    (spc_en),
        .chars     (chars)
    );

    uart_swfc_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .spc_en    (spc_en),
        .chars     (chars),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .irq_clr   (irq_clr),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .tx_halt   (tx_halt),
        .spc_irq   (spc_irq)
    );

    uart_swfc_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .chars     (chars),
        .lvl_hi    (lvl_hi),
        .lvl_lo    (lvl_lo),
        .send_xoff (send_xoff),
        .send_xon  (send_xon),
        .tx_two    (tx_two),
        .tx_char_a (tx_char_a),
        .tx_char_b (tx_char_b)
    );
endmodule

// File: rtl/uart_swfc_chk.sv
// Checker for the flow-control engine, bound into the top module.
// Assumes it sees the top's configuration signals by name.
module uart_swfc_chk
    import uart_swfc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_valid,
    input logic [CHAR_W-1:0]      rx_data,
    input logic                   fifo_wr,
    input logic [CHAR_W-1:0]      fifo_data,
    input logic                   tx_halt,
    input logic                   send_xon,
    input logic                   send_xoff,
    input logic                   tx_two,
    input logic                   spc_irq,
    input logic                   irq_clr,
    input logic [MODE_W-1:0]      mode,
    input logic                   spc_en,
    input char_t [NUM_CHARS-1:0]  chars
);
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_xon && send_xoff)); // R8
    AST_PAIR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_two |-> ((send_xon || send_xoff) && $past(mode[3:2]) == 2'b11)); // R8
    AST_TX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3:2] == 2'b00) |=> (!send_xon && !send_xoff)); // R9
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode[1:0] == 2'b00) |=> (fifo_wr && fifo_data == $past(rx_data))); // R3
    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode[1:0] == 2'b10 && rx_data == chars[2]) |=> (tx_halt && !fifo_wr)); // R4
    AST_HALT_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> $past(rx_valid)); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_irq && !irq_clr) |=> spc_irq); // R11
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode == '0 && spc_en && rx_data == chars[3]) |=> spc_irq); // R10
    AST_RX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
endmodule

bind uart_swfc uart_swfc_chk u_chk (.*);

// File: tb/uart_swfc_tb.sv
`timescale 1ns/100ps
module uart_swfc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       chr_we = 1'b0;
    logic [1:0] chr_sel = '0;
    logic [7:0] chr_wdata = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       fifo_wr, tx_halt, send_xoff, send_xon, tx_two, spc_irq;
    logic [7:0] fifo_data, tx_char_a, tx_char_b;
    logic       lvl_hi = 1'b0, lvl_lo = 1'b0, irq_clr = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h12, XOFF1 = 8'h13, XOFF2 = 8'h14;

    // {mode[3:0], rx byte, expected wr, expected data, expected halt}
    localparam int NVEC = 13;
    localparam logic [21:0] VEC [NVEC] = '{
        {4'b0000, 8'h41, 1'b1, 8'h41, 1'b0},   // R3
        {4'b0000, XOFF1, 1'b1, XOFF1, 1'b0},   // R3
        {4'b0010, XOFF1, 1'b0, 8'h00, 1'b1},   // R4
        {4'b0010, 8'h41, 1'b1, 8'h41, 1'b1},   // R4
        {4'b0010, XOFF2, 1'b1, XOFF2, 1'b1},   // R4
        {4'b0010, XON1,  1'b0, 8'h00, 1'b0},   // R4
        {4'b0001, XOFF2, 1'b0, 8'h00, 1'b1},   // R5
        {4'b0001, XOFF1, 1'b1, XOFF1, 1'b1},   // R5
        {4'b0001, XON2,  1'b0, 8'h00, 1'b0},   // R5
        {4'b0011, XOFF1, 1'b0, 8'h00, 1'b0},   // R6
        {4'b0011, XOFF2, 1'b0, 8'h00, 1'b1},   // R6
        {4'b0011, XON1,  1'b0, 8'h00, 1'b1},   // R6
        {4'b0011, XON2,  1'b0, 8'h00, 1'b0}    // R6
    };

    uart_swfc u_dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl_write(input logic [5:0] w);
        ctl_we = 1'b1; ctl_wdata = w;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic chr_write(input logic [1:0] s, input logic [7:0] c);
        chr_we = 1'b1; chr_sel = s; chr_wdata = c;
        tick();
        chr_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        tick();
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] cur_mode;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 fifo_wr", fifo_wr, 0);
        check("R1 tx_halt", tx_halt, 0);
        check("R1 send_xoff", send_xoff, 0);
        check("R1 send_xon", send_xon, 0);
        check("R1 spc_irq", spc_irq, 0);
        check("R1 tx_two", tx_two, 0);

        chr_write(2'd0, XON1);
        chr_write(2'd1, XON2);
        chr_write(2'd2, XOFF1);
        chr_write(2'd3, XOFF2);

        // R2: locked write of mode 0010 must be ignored; stop char still passes
        ctl_write(6'b000010);
        send(XOFF1);
        check("R2 locked wr", fifo_wr, 1);
        check("R2 locked data", fifo_data, XOFF1);
        ctl_write(6'b100010);   // unlocks; mode still guarded by old lock
        tick();
        send(XOFF1);
        check("R2 unlock-write wr", fifo_wr, 1);
        check("R2 unlock-write halt", tx_halt, 0);

        // Vector table: receive classification
        cur_mode = 4'hF;
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][21:18] != cur_mode) begin
                cur_mode = VEC[i][21:18];
                ctl_write({2'b10, cur_mode});
                tick();
            end
            send(VEC[i][17:10]);
            check($sformatf("R3-6 vec%0d wr", i), fifo_wr, VEC[i][9]);
            if (VEC[i][9])
                check($sformatf("R3-6 vec%0d data", i), fifo_data, VEC[i][8:1]);
            check($sformatf("R3-6 vec%0d halt", i), tx_halt, VEC[i][0]);
            tick();
        end

        // R7: broken pair, mode 11
        send(XOFF1);
        check("R7 held", fifo_wr, 0);
        tick();
        send(8'h41);
        check("R7 held out wr", fifo_wr, 1);
        check("R7 held out data", fifo_data, XOFF1);
        tick();
        check("R7 second wr", fifo_wr, 1);
        check("R7 second data", fifo_data, 8'h41);
        tick();
        send(XON1);
        tick();
        send(XOFF1);
        check("R7 rehold wr", fifo_wr, 1);
        check("R7 rehold data", fifo_data, XON1);
        tick();
        check("R7 rehold no extra", fifo_wr, 0);
        send(XOFF2);
        check("R7 rehold pair halt", tx_halt, 1);
        check("R7 rehold pair wr", fifo_wr, 0);

        // R12: receive mode 00 clears halt
        ctl_write(6'b100000);
        tick();
        check("R12 halt cleared", tx_halt, 0);

        // R9: transmit off, no request
        lvl_hi = 1'b1;
        tick();
        check("R9 no xoff", send_xoff, 0);
        lvl_hi = 1'b0;

        // R8: transmit set 1
        ctl_write(6'b101000);
        lvl_hi = 1'b1;
        tick();
        check("R8 xoff pulse", send_xoff, 1);
        check("R8 xoff char", tx_char_a, XOFF1);
        check("R8 single", tx_two, 0);
        tick();
        check("R8 no repeat", send_xoff, 0);
        lvl_hi = 1'b0; lvl_lo = 1'b1;
        tick();
        check("R8 xon pulse", send_xon, 1);
        check("R8 xon char", tx_char_a, XON1);
        lvl_lo = 1'b0;
        // pair
        ctl_write(6'b101100);
        lvl_hi = 1'b1;
        tick();
        lvl_hi = 1'b0;
        check("R8 pair xoff", send_xoff, 1);
        check("R8 pair two", tx_two, 1);
        check("R8 pair a", tx_char_a, XOFF1);
        check("R8 pair b", tx_char_b, XOFF2);
        lvl_lo = 1'b1;
        tick();
        lvl_lo = 1'b0;
        check("R8 pair xon", send_xon, 1);
        check("R8 pair xon a", tx_char_a, XON1);
        check("R8 pair xon b", tx_char_b, XON2);
        // set 2
        ctl_write(6'b100100);
        lvl_hi = 1'b1;
        tick();
        lvl_hi = 1'b0;
        check("R8 set2 xoff", send_xoff, 1);
        check("R8 set2 char", tx_char_a, XOFF2);
        lvl_lo = 1'b1;
        tick();
        lvl_lo = 1'b0;

        // R10: special character with mode 0
        ctl_write(6'b110000);
        send(XOFF2);
        check("R10 stored wr", fifo_wr, 1);
        check("R10 stored data", fifo_data, XOFF2);
        check("R10 flag", spc_irq, 1);
        // R11: sticky, clear, set wins
        repeat (2) tick();
        check("R11 sticky", spc_irq, 1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        check("R11 cleared", spc_irq, 0);
        tick();
        irq_clr = 1'b1;
        send(XOFF2);
        irq_clr = 1'b0;
        check("R11 set wins", spc_irq, 1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        // R10: flag not raised with mode bits set
        ctl_write(6'b110010);
        send(XOFF2);
        check("R10 mode set no flag", spc_irq, 0);
        check("R10 mode set passes", fifo_wr, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule